// File: doc/BRIEF.md
# In-Order Issue Stage with Destination Renaming

This block sits between an instruction decoder and a pool of fifteen reservation stations. Decoded instructions enter a small FIFO, one per cycle at most. On each cycle the stage looks at the instruction at the head of that FIFO. If a station of the required class is free, the stage allocates it, moves the instruction into it, and pops the FIFO. Source operands do not have to be ready for this to happen.

When an instruction issues, the stage reads both source registers from the register file. A source whose tag is zero is passed on as a value. Any other source is passed on as the tag of the station that will produce it. The stage then asks the register file to overwrite the destination register's tag with the allocated station's ID. From that point the register waits on that station. Stores do not rename anything.

Every output of the stage is registered. The register file and the station pool therefore see an allocation one cycle after it is decided. The stage covers that one-cycle gap itself, so that two back-to-back dependent instructions stay correct.

Top module: `issue_rename_unit`

## Requirements
- R1: Instruction class is encoded as 0 = store, 1 = load, 2 = add/subtract, 3 = multiply/divide. Station IDs are 4-bit values: stores use 1..5, loads 6..10, add/subtract 11..13 and multiply/divide 14..15. ID 0 means "no station". An issued ID always lies in the range of the head instruction's class.
- R2: Within its class, the lowest-numbered station whose `stn_free` bit is set is allocated. Bit i of `stn_free` describes station ID i+1.
- R3: The head instruction issues when its class has a free station, regardless of its operand tags. When its class has no free station, nothing issues and the FIFO keeps the instruction. An issue decided at a clock edge shows as `iss_valid` high for the cycle that follows that edge.
- R4: For each source, a register tag of 0 produces tag 0 and the register's value. A nonzero tag produces that tag and a value of 0.
- R5: A load, add/subtract or multiply/divide issue raises `ren_valid` in the same cycle as `iss_valid`, with `ren_addr` set to the destination register and `ren_tag` set to the issued station ID.
- R6: A store issue leaves `ren_valid` low. With no issue, `ren_valid` is low.
- R7: The register file applies a rename at the clock edge after `ren_valid` is seen. A source matching the rename currently on the rename port therefore takes that rename's tag (and value 0) instead of the register file's tag.
- R8: The station issued in the current cycle counts as taken for the next decision, even if `stn_free` still shows it as free. No ID is issued in two consecutive cycles.
- R9: Instructions issue in the order they were accepted. `in_ready` is low exactly when the FIFO holds DEPTH entries, and a push offered while `in_ready` is low is dropped.
- R10: After reset, `iss_valid` and `ren_valid` are low and `in_ready` is high. An empty FIFO never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoder offers an instruction |
| in_ready | output | 1 | FIFO has room |
| in_cls | input | 2 | Instruction class (R1 encoding) |
| in_op | input | OP_W | Operation selector passed to the station |
| in_dst | input | REG_AW | Destination register |
| in_srcj | input | REG_AW | First source register |
| in_srck | input | REG_AW | Second source register |
| stn_free | input | 15 | Free flag per station, bit i = ID i+1 |
| rf_raddr_j | output | REG_AW | Register file read address, first source |
| rf_raddr_k | output | REG_AW | Register file read address, second source |
| rf_rdata_j | input | DATA_W | Value of first source |
| rf_rdata_k | input | DATA_W | Value of second source |
| rf_rtag_j | input | TAG_W | Tag of first source |
| rf_rtag_k | input | TAG_W | Tag of second source |
| ren_valid | output | 1 | Rename write request |
| ren_addr | output | REG_AW | Register to rename |
| ren_tag | output | TAG_W | New tag for that register |
| iss_valid | output | 1 | Station allocation strobe |
| iss_id | output | TAG_W | Allocated station ID |
| iss_op | output | OP_W | Operation for the station |
| iss_vj | output | DATA_W | First operand value |
| iss_vk | output | DATA_W | Second operand value |
| iss_qj | output | TAG_W | First operand tag |
| iss_qk | output | TAG_W | Second operand tag |

## Verification
A corrupted FIFO pointer or count shows up at the next issue. It appears as a wrong `iss_op` order or a wrong `in_ready` level within a cycle of the corruption. A stale or missing rename bypass register appears in the very next cycle in which a dependent instruction issues. That instruction carries the old register-file tag on `iss_qj` or `iss_qk`. A missing taken-mask appears as the same station ID issued twice in a row. That only happens when the freshly allocated station is the lowest free one in its class, so the stimulus keeps pools nearly empty and nearly full.

// File: rtl/issue_pkg.sv
package issue_pkg;
  typedef enum logic [1:0] {
    CLS_STORE  = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_ADDSUB = 2'd2,
    CLS_MULDIV = 2'd3
  } iclass_e;

  localparam int NUM_CLS = 4;
endpackage

// File: rtl/iq_fifo.sv
module iq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/iq_station_pick.sv
module iq_station_pick import issue_pkg::*; #(
  parameter int N_STORE = 5,
  parameter int N_LOAD  = 5,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int TAG_W   = 4,
  localparam int NSTN   = N_STORE + N_LOAD + N_ADD + N_MUL
) (
  input  iclass_e          cls,
  input  logic [NSTN-1:0]  avail,
  output logic             found,
  output logic [TAG_W-1:0] id
);
  function automatic int cls_lo(input int c);
    case (c)
      0:       return 1;
      1:       return 1 + N_STORE;
      2:       return 1 + N_STORE + N_LOAD;
      default: return 1 + N_STORE + N_LOAD + N_ADD;
    endcase
  endfunction

  function automatic int cls_cnt(input int c);
    case (c)
      0:       return N_STORE;
      1:       return N_LOAD;
      2:       return N_ADD;
      default: return N_MUL;
    endcase
  endfunction

  logic [NUM_CLS-1:0] f_c;
  logic [TAG_W-1:0]   id_c [NUM_CLS];

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    localparam int LO  = cls_lo(c);
    localparam int CNT = cls_cnt(c);
    logic             fc;
    logic [TAG_W-1:0] idc;

    // scan downward so the lowest free ID wins
    always_comb begin
      fc  = 1'b0;
      idc = '0;
      for (int i = CNT - 1; i >= 0; i--) begin
        if (avail[LO - 1 + i]) begin
          fc  = 1'b1;
          idc = TAG_W'(LO + i);
        end
      end
    end

    assign f_c[c]  = fc;
    assign id_c[c] = idc;
  end

  assign found = f_c[cls];
  assign id    = id_c[cls];
endmodule

// File: rtl/iq_operand.sv
module iq_operand #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [TAG_W-1:0]  rf_tag,
  input  logic              byp_valid,
  input  logic [REG_AW-1:0] byp_addr,
  input  logic [TAG_W-1:0]  byp_tag,
  output logic [TAG_W-1:0]  q,
  output logic [DATA_W-1:0] v
);
  // rename still in flight to the register file overrides its tag
  always_comb begin
    q = (byp_valid && (byp_addr == src)) ? byp_tag : rf_tag;
    v = (q == '0) ? rf_data : '0;
  end
endmodule

// File: rtl/issue_rename_unit.sv
module issue_rename_unit import issue_pkg::*; #(
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 64,
  parameter int REG_AW  = 5,
  parameter int OP_W    = 3,
  parameter int N_STORE = 5,
  parameter int N_LOAD  = 5,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int TAG_W   = 4,
  localparam int NSTN   = N_STORE + N_LOAD + N_ADD + N_MUL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_cls,
  input  logic [OP_W-1:0]   in_op,
  input  logic [REG_AW-1:0] in_dst,
  input  logic [REG_AW-1:0] in_srcj,
  input  logic [REG_AW-1:0] in_srck,
  input  logic [NSTN-1:0]   stn_free,
  output logic [REG_AW-1:0] rf_raddr_j,
  output logic [REG_AW-1:0] rf_raddr_k,
  input  logic [DATA_W-1:0] rf_rdata_j,
  input  logic [DATA_W-1:0] rf_rdata_k,
  input  logic [TAG_W-1:0]  rf_rtag_j,
  input  logic [TAG_W-1:0]  rf_rtag_k,
  output logic              ren_valid,
  output logic [REG_AW-1:0] ren_addr,
  output logic [TAG_W-1:0]  ren_tag,
  output logic              iss_valid,
  output logic [TAG_W-1:0]  iss_id,
  output logic [OP_W-1:0]   iss_op,
  output logic [DATA_W-1:0] iss_vj,
  output logic [DATA_W-1:0] iss_vk,
  output logic [TAG_W-1:0]  iss_qj,
  output logic [TAG_W-1:0]  iss_qk
);
  localparam int ENT_W = 2 + OP_W + 3 * REG_AW;
  localparam int NSRC  = 2;

  logic [ENT_W-1:0]  push_ent, head_ent;
  logic              q_full, q_empty, do_push, do_issue;
  iclass_e           h_cls;
  logic [OP_W-1:0]   h_op;
  logic [REG_AW-1:0] h_dst, h_sj, h_sk;
  logic [NSTN-1:0]   taken, avail;
  logic              pick_ok;
  logic [TAG_W-1:0]  pick_id;

  assign push_ent = {in_cls, in_op, in_dst, in_srcj, in_srck};
  assign do_push  = in_valid && !q_full;
  assign in_ready = !q_full;

  iq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (do_push),
    .pop   (do_issue),
    .din   (push_ent),
    .head  (head_ent),
    .full  (q_full),
    .empty (q_empty)
  );

  assign h_cls = iclass_e'(head_ent[ENT_W-1 -: 2]);
  assign {h_op, h_dst, h_sj, h_sk} = head_ent[ENT_W-3:0];

  // station handed out last cycle is not yet visible as busy upstream
  assign taken = iss_valid ? (NSTN'(1) << (iss_id - TAG_W'(1))) : '0;
  assign avail = stn_free & ~taken;

  iq_station_pick #(
    .N_STORE(N_STORE), .N_LOAD(N_LOAD), .N_ADD(N_ADD), .N_MUL(N_MUL),
    .TAG_W(TAG_W)
  ) u_pick (
    .cls   (h_cls),
    .avail (avail),
    .found (pick_ok),
    .id    (pick_id)
  );

  assign do_issue = !q_empty && pick_ok;

  assign rf_raddr_j = h_sj;
  assign rf_raddr_k = h_sk;

  logic [REG_AW-1:0] src_a  [NSRC];
  logic [DATA_W-1:0] rdat_a [NSRC];
  logic [TAG_W-1:0]  rtag_a [NSRC];
  logic [TAG_W-1:0]  q_a    [NSRC];
  logic [DATA_W-1:0] v_a    [NSRC];

  assign src_a[0]  = h_sj;
  assign src_a[1]  = h_sk;
  assign rdat_a[0] = rf_rdata_j;
  assign rdat_a[1] = rf_rdata_k;
  assign rtag_a[0] = rf_rtag_j;
  assign rtag_a[1] = rf_rtag_k;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    iq_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W), .REG_AW(REG_AW)) u_opnd (
      .src       (src_a[s]),
      .rf_data   (rdat_a[s]),
      .rf_tag    (rtag_a[s]),
      .byp_valid (ren_valid),
      .byp_addr  (ren_addr),
      .byp_tag   (ren_tag),
      .q         (q_a[s]),
      .v         (v_a[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      ren_valid <= 1'b0;
    end else begin
      iss_valid <= do_issue;
      ren_valid <= do_issue && (h_cls != CLS_STORE);
    end
  end

  always_ff @(posedge clk) begin
    if (do_issue) begin
      iss_id   <= pick_id;
      iss_op   <= h_op;
      iss_qj   <= q_a[0];
      iss_qk   <= q_a[1];
      iss_vj   <= v_a[0];
      iss_vk   <= v_a[1];
      ren_addr <= h_dst;
      ren_tag  <= pick_id;
    end
  end
endmodule

// File: rtl/issue_rename_unit_chk.sv
module issue_rename_unit_chk #(
  parameter int N_STORE = 5,
  parameter int TAG_W   = 4,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 64,
  parameter int NSTN    = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [NSTN-1:0]   stn_free,
  input logic [REG_AW-1:0] rf_raddr_j,
  input logic [REG_AW-1:0] rf_raddr_k,
  input logic              iss_valid,
  input logic [TAG_W-1:0]  iss_id,
  input logic [TAG_W-1:0]  iss_qj,
  input logic [TAG_W-1:0]  iss_qk,
  input logic [DATA_W-1:0] iss_vj,
  input logic [DATA_W-1:0] iss_vk,
  input logic              ren_valid,
  input logic [REG_AW-1:0] ren_addr,
  input logic [TAG_W-1:0]  ren_tag
);
  a_r1_id_legal: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (iss_id != '0) && (int'(iss_id) <= NSTN));

  a_r3_was_free: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (|(($past(stn_free) >> (iss_id - TAG_W'(1))) & NSTN'(1))));

  a_r4_tag_zeroes_value: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> ((iss_qj == '0) || (iss_vj == '0)) && ((iss_qk == '0) || (iss_vk == '0)));

  a_r5_ren_matches_issue: assert property (@(posedge clk) disable iff (rst)
    ren_valid |-> iss_valid && (ren_tag == iss_id));

  a_r6_store_no_ren: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && (int'(iss_id) <= N_STORE)) |-> !ren_valid);

  a_r7_bypass_j: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && $past(ren_valid) && ($past(rf_raddr_j) == $past(ren_addr)))
      |-> (iss_qj == $past(ren_tag)));

  a_r7_bypass_k: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && $past(ren_valid) && ($past(rf_raddr_k) == $past(ren_addr)))
      |-> (iss_qk == $past(ren_tag)));

  a_r8_no_reuse: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && $past(iss_valid)) |-> (iss_id != $past(iss_id)));
endmodule

bind issue_rename_unit issue_rename_unit_chk #(
  .N_STORE(N_STORE), .TAG_W(TAG_W), .REG_AW(REG_AW), .DATA_W(DATA_W), .NSTN(NSTN)
) u_chk (.*);

// File: tb/issue_rename_unit_test.sv
module issue_rename_unit_test;
  localparam int DEPTH = 4;
  localparam int DW    = 64;
  localparam int RAW   = 5;
  localparam int OPW   = 3;
  localparam int TW    = 4;
  localparam int NS    = 15;
  localparam int NREG  = 32;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready;
  logic [1:0] in_cls;
  logic [OPW-1:0] in_op;
  logic [RAW-1:0] in_dst, in_srcj, in_srck;
  logic [NS-1:0] stn_free;
  logic [RAW-1:0] rf_raddr_j, rf_raddr_k;
  logic [DW-1:0] rf_rdata_j, rf_rdata_k;
  logic [TW-1:0] rf_rtag_j, rf_rtag_k;
  logic ren_valid;
  logic [RAW-1:0] ren_addr;
  logic [TW-1:0] ren_tag;
  logic iss_valid;
  logic [TW-1:0] iss_id, iss_qj, iss_qk;
  logic [OPW-1:0] iss_op;
  logic [DW-1:0] iss_vj, iss_vk;

  always #2 clk = ~clk;

  // environment: register file and station pool
  logic [DW-1:0] rf_val [NREG];
  logic [TW-1:0] rf_tag [NREG];
  logic [NS-1:0] busy;
  assign stn_free   = ~busy;
  assign rf_rdata_j = rf_val[rf_raddr_j];
  assign rf_rdata_k = rf_val[rf_raddr_k];
  assign rf_rtag_j  = rf_tag[rf_raddr_j];
  assign rf_rtag_k  = rf_tag[rf_raddr_k];

  issue_rename_unit uut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference queue
  logic [1:0]     q_cls [16];
  logic [OPW-1:0] q_op  [16];
  logic [RAW-1:0] q_dst [16], q_sj [16], q_sk [16];
  int qh = 0, qt = 0, qn = 0;

  // expectation for the current output cycle
  logic p_valid = 0, p_ren = 0;
  logic [1:0] p_cls;
  logic [TW-1:0] p_id, p_qj, p_qk;
  logic [OPW-1:0] p_op;
  logic [DW-1:0] p_vj, p_vk;
  logic [RAW-1:0] p_dst;

  logic pend_alloc = 0, pend_ren = 0;
  logic [TW-1:0] pend_id, pend_tag;
  logic [RAW-1:0] pend_addr;
  logic [RAW-1:0] last_dst = '0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int cls_lo(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 6;
      2'd2: return 11;
      default: return 14;
    endcase
  endfunction

  function automatic int cls_n(input logic [1:0] c);
    case (c)
      2'd0, 2'd1: return 5;
      2'd2: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [TW-1:0] exp_pick(input logic [1:0] c, input logic [NS-1:0] fv);
    logic [TW-1:0] r = '0;
    for (int i = cls_n(c) - 1; i >= 0; i--)
      if (fv[cls_lo(c) - 1 + i]) r = TW'(cls_lo(c) + i);
    return r;
  endfunction

  task automatic cycle(input int fpct, input int push_pct, input bit dep);
    logic pv, pren;
    logic [TW-1:0] pid, id, tj, tk;
    logic [RAW-1:0] pdst;
    logic [NS-1:0] fv;
    @(negedge clk);
    // compare outputs with the expectation for this cycle
    chk(iss_valid == p_valid, "R3 R10 issue strobe", 64'(iss_valid), 64'(p_valid));
    if (p_valid && iss_valid) begin
      chk(iss_id == p_id, "R2 R8 station id", 64'(iss_id), 64'(p_id));
      chk(int'(iss_id) >= cls_lo(p_cls) && int'(iss_id) < cls_lo(p_cls) + cls_n(p_cls),
          "R1 id within class", 64'(iss_id), 64'(cls_lo(p_cls)));
      chk(iss_op == p_op, "R9 order op", 64'(iss_op), 64'(p_op));
      chk(iss_qj == p_qj, "R7 tag j", 64'(iss_qj), 64'(p_qj));
      chk(iss_qk == p_qk, "R7 tag k", 64'(iss_qk), 64'(p_qk));
      chk(iss_vj == p_vj, "R4 value j", iss_vj, p_vj);
      chk(iss_vk == p_vk, "R4 value k", iss_vk, p_vk);
      chk(ren_valid == p_ren, "R6 rename strobe", 64'(ren_valid), 64'(p_ren));
      if (p_ren && ren_valid) begin
        chk(ren_addr == p_dst, "R5 rename addr", 64'(ren_addr), 64'(p_dst));
        chk(ren_tag == p_id, "R5 rename tag", 64'(ren_tag), 64'(p_id));
      end
    end else if (!p_valid) begin
      chk(!ren_valid, "R6 no rename without issue", 64'(ren_valid), 64'd0);
    end
    chk(in_ready == (qn < DEPTH), "R9 ready level", 64'(in_ready), 64'(qn < DEPTH));

    // environment sees last cycle's allocation and rename now
    if (pend_alloc) busy[pend_id - 1] = 1'b1;
    if (pend_ren) rf_tag[pend_addr] = pend_tag;
    for (int s = 0; s < NS; s++) begin
      if (busy[s] && (($urandom % 100) < fpct)) begin
        busy[s] = 1'b0;
        for (int r = 0; r < NREG; r++)
          if (rf_tag[r] == TW'(s + 1)) rf_tag[r] = '0;
      end
    end
    pend_alloc = iss_valid; pend_id = iss_id;
    pend_ren = ren_valid; pend_addr = ren_addr; pend_tag = ren_tag;

    // predict the next issue
    pv = p_valid; pid = p_id; pren = p_ren; pdst = p_dst;
    p_valid = 1'b0; p_ren = 1'b0;
    if (qn > 0) begin
      fv = ~busy & ~(pv ? (NS'(1) << (pid - TW'(1))) : '0);
      id = exp_pick(q_cls[qh], fv);
      if (id != '0) begin
        tj = (pren && pdst == q_sj[qh]) ? pid : rf_tag[q_sj[qh]];
        tk = (pren && pdst == q_sk[qh]) ? pid : rf_tag[q_sk[qh]];
        p_valid = 1'b1; p_id = id; p_cls = q_cls[qh]; p_op = q_op[qh];
        p_qj = tj; p_qk = tk;
        p_vj = (tj == '0) ? rf_val[q_sj[qh]] : '0;
        p_vk = (tk == '0) ? rf_val[q_sk[qh]] : '0;
        p_ren = (q_cls[qh] != 2'd0); p_dst = q_dst[qh];
        qh = (qh + 1) % 16; qn--;
      end
    end

    // new decoder input
    in_valid = (($urandom % 100) < push_pct);
    in_cls   = dep ? 2'(1 + ($urandom % 3)) : 2'($urandom % 4);
    in_op    = OPW'($urandom);
    in_dst   = RAW'($urandom % 8);
    in_srcj  = dep ? last_dst : RAW'($urandom % 8);
    in_srck  = RAW'($urandom % 8);
    if (in_valid && in_ready) begin
      q_cls[qt] = in_cls; q_op[qt] = in_op; q_dst[qt] = in_dst;
      q_sj[qt] = in_srcj; q_sk[qt] = in_srck;
      qt = (qt + 1) % 16; qn++;
      if (in_cls != 2'd0) last_dst = in_dst;
    end
  endtask

  task automatic run(input int ncyc, input int fpct, input int push_pct, input bit dep);
    for (int c = 0; c < ncyc; c++) cycle(fpct, push_pct, dep);
  endtask

  initial begin
    void'($urandom(32'd501));
    for (int r = 0; r < NREG; r++) begin
      rf_val[r] = {$urandom, $urandom};
      rf_tag[r] = '0;
    end
    busy = '0;
    rst = 1'b1; in_valid = 1'b0; in_cls = '0; in_op = '0;
    in_dst = '0; in_srcj = '0; in_srck = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(!iss_valid, "R10 reset iss_valid", 64'(iss_valid), 64'd0);
    chk(!ren_valid, "R10 reset ren_valid", 64'(ren_valid), 64'd0);
    chk(in_ready, "R10 reset in_ready", 64'(in_ready), 64'd1);
    run(60, 0, 100, 1'b0);     // pools exhaust, FIFO fills (R3, R9)
    run(60, 40, 0, 1'b0);      // drain to empty (R10)
    run(300, 60, 100, 1'b1);   // dependent chains (R7, R8)
    for (int b = 0; b < 20; b++)
      run(100, $urandom % 70, 20 + ($urandom % 80), b[0]);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule